// File: doc/BRIEF.md
# Code-Selected Fractional Clock Divider

This block derives a master clock from a fast reference clock (nominally 48 MHz). The divide ratio comes from a 6-bit select code. In a larger control word this code sits in bits 7 down to 2 of an 8-bit field; the block receives only the six code bits. A sparse table maps a few codes to whole-number ratios and a few to half-integer ratios. Every code outside the table produces the reference clock undivided.

Half-integer ratios need resolution finer than one reference cycle. The block therefore works in reference half-cycles. One flop on the rising edge and one on the falling edge each toggle, and their XOR forms the output, so the output can change on either reference edge. A new code is adopted only where an output period begins. An enable input parks the output low, and when enable rises the output restarts with a full first period.

Top module: `ratio_clk_div`

## Requirements
- R1: Each whole-ratio code gives an output period of 2N reference half-cycles, rising edge to rising edge. The codes and ratios are: 2 divides by 2, 4 by 3, 6 by 4, 7 by 5, 8 by 6, 9 by 7, 18 by 16, and 50 by 48.
- R2: The half-integer codes give periods of an odd number of half-cycles. Code 1 gives 3 half-cycles (divide by 1.5). Code 3 gives 5 (divide by 2.5). Code 5 gives 7 (divide by 3.5).
- R3: Code 0 passes the reference through undivided, with a period of 2 half-cycles. Every code not named in R1 or R2 does the same, for example 10, 17, 33 and 63.
- R4: For a period of P half-cycles, the output is high for ceil(P/2) half-cycles, starting at the rising edge, and low for the rest.
- R5: A code change takes effect only at the next output rising edge. The period in progress completes with its old high and low lengths, and the period after that edge uses the new code.
- R6: While enable is low, the output is low from the first reference rising edge after enable falls, and it makes no edges.
- R7: When enable rises, the output rises at the next reference rising edge, and that first period is complete, with its full high and low lengths.
- R8: While rstN is low, the output is low, and rstN takes effect asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Output runs while high and is held low while low |
| ratioCode | input | 6 | Divide-ratio select code |
| clkOut | output | 1 | Divided master clock |

## Verification
The bench counts reference half-cycles between output edges for every listed code and for several unlisted codes. A wrong table entry or a lost fallback shows up as a wrong period or a wrong high time. It changes the code from the slowest ratio to the fastest in the middle of a period. A divider that switches at once would cut that period short and leave a runt. It also drops and raises enable. A divider that resumed from a stale phase counter would produce a partial first period, and one that ignored enable would keep toggling. Finally, it pulls reset low during a high phase, which a divider with a synchronous reset would miss.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  localparam int CODE_W = 6;
  localparam int LEN_W = 7;
  localparam int PASS_LEN = 2;

  typedef logic [LEN_W-1:0] len_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic run;
    logic levA;
    logic levB;
  } strobe_t;

  function automatic len_t decodeLen(input code_t code);
    case (code)
      CODE_W'(1):  return len_t'(3);
      CODE_W'(2):  return len_t'(4);
      CODE_W'(3):  return len_t'(5);
      CODE_W'(4):  return len_t'(6);
      CODE_W'(5):  return len_t'(7);
      CODE_W'(6):  return len_t'(8);
      CODE_W'(7):  return len_t'(10);
      CODE_W'(8):  return len_t'(12);
      CODE_W'(9):  return len_t'(14);
      CODE_W'(18): return len_t'(32);
      CODE_W'(50): return len_t'(96);
      default:     return len_t'(PASS_LEN);
    endcase
  endfunction

  function automatic len_t highLen(input len_t p);
    return p - (p >> 1);
  endfunction
endpackage

// File: rtl/rcd_ctrl.sv
module rcd_ctrl
  import rcd_pkg::*;
(
  input  logic    refClk,
  input  logic    rstN,
  input  logic    enable,
  input  code_t   ratioCode,
  output strobe_t strobe
);
  len_t curIdx;
  len_t activeLen;
  len_t reqLen;
  len_t effLen;
  len_t idxB;
  len_t idxPlus1;
  len_t idxPlus2;
  len_t nextIdx;
  len_t nextLen;
  logic atRise;
  logic midRise;

  always_comb begin
    reqLen   = decodeLen(ratioCode);
    idxPlus1 = curIdx + len_t'(1);
    idxPlus2 = curIdx + len_t'(2);
    atRise   = (curIdx == '0);
    midRise  = (idxPlus1 == activeLen);
    effLen   = atRise ? reqLen : activeLen;
    nextLen  = (atRise || midRise) ? reqLen : activeLen;
    idxB     = midRise ? '0 : idxPlus1;
    if (midRise) begin
      nextIdx = len_t'(1);
    end else if (idxPlus2 >= effLen) begin
      nextIdx = idxPlus2 - effLen;
    end else begin
      nextIdx = idxPlus2;
    end
    strobe.run  = enable;
    strobe.levA = (curIdx < highLen(effLen));
    strobe.levB = midRise ? 1'b1 : (idxB < highLen(effLen));
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      curIdx    <= '0;
      activeLen <= len_t'(PASS_LEN);
    end else if (!enable) begin
      curIdx    <= '0;
      activeLen <= reqLen;
    end else begin
      curIdx    <= nextIdx;
      activeLen <= nextLen;
    end
  end
endmodule

// File: rtl/rcd_datapath.sv
module rcd_datapath
  import rcd_pkg::*;
(
  input  logic    refClk,
  input  logic    rstN,
  input  strobe_t strobe,
  output logic    clkOut
);
  logic posFlop;
  logic negFlop;
  logic levBReg;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      posFlop <= 1'b0;
      levBReg <= 1'b0;
    end else if (!strobe.run) begin
      posFlop <= negFlop;
      levBReg <= 1'b0;
    end else begin
      posFlop <= strobe.levA ^ negFlop;
      levBReg <= strobe.levB;
    end
  end

  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) begin
      negFlop <= 1'b0;
    end else begin
      negFlop <= levBReg ^ posFlop;
    end
  end

  assign clkOut = posFlop ^ negFlop;
endmodule

// File: rtl/ratio_clk_div.sv
module ratio_clk_div
  import rcd_pkg::*;
(
  input  logic              refClk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CODE_W-1:0] ratioCode,
  output logic              clkOut
);
  strobe_t strobe;

  rcd_ctrl uCtrl (
    .refClk   (refClk),
    .rstN     (rstN),
    .enable   (enable),
    .ratioCode(ratioCode),
    .strobe   (strobe)
  );

  rcd_datapath uData (
    .refClk(refClk),
    .rstN  (rstN),
    .strobe(strobe),
    .clkOut(clkOut)
  );
endmodule

// File: rtl/rcd_checker.sv
module rcd_checker
  import rcd_pkg::*;
(
  input logic refClk,
  input logic rstN,
  input logic enable,
  input logic clkOut,
  input len_t curIdx,
  input len_t activeLen
);
  AST_HOLD_LOW: assert property (@(posedge refClk) disable iff (!rstN)
    !enable |=> !clkOut); // R6

  AST_START_PHASE: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(enable) |-> (curIdx == '0)); // R7

  AST_LOAD_AT_RISE: assert property (@(posedge refClk) disable iff (!rstN)
    (activeLen != $past(activeLen)) |->
      ($past(curIdx) == '0 || ($past(curIdx) + len_t'(1)) == $past(activeLen) || !$past(enable))); // R5

  AST_IDX_RANGE: assert property (@(posedge refClk) disable iff (!rstN)
    curIdx < activeLen); // R1

  AST_LEN_FLOOR: assert property (@(posedge refClk) disable iff (!rstN)
    activeLen >= len_t'(PASS_LEN)); // R3
endmodule

bind ratio_clk_div rcd_checker uChk (
  .refClk   (refClk),
  .rstN     (rstN),
  .enable   (enable),
  .clkOut   (clkOut),
  .curIdx   (uCtrl.curIdx),
  .activeLen(uCtrl.activeLen)
);

// File: tb/ratio_clk_div_test.sv
module ratio_clk_div_test;
  logic       refClk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic [5:0] ratioCode = '0;
  logic       clkOut;

  int checks = 0;
  int errors = 0;
  int halfCnt = 0;
  int cycles = 0;

  localparam int NV = 16;
  // code, period in half-cycles, high half-cycles
  localparam int VEC [NV][3] = '{
    '{0, 2, 1}, '{1, 3, 2}, '{2, 4, 2}, '{3, 5, 3},
    '{4, 6, 3}, '{5, 7, 4}, '{6, 8, 4}, '{7, 10, 5},
    '{8, 12, 6}, '{9, 14, 7}, '{18, 32, 16}, '{50, 96, 48},
    '{10, 2, 1}, '{17, 2, 1}, '{33, 2, 1}, '{63, 2, 1}
  };

  ratio_clk_div uut (
    .refClk   (refClk),
    .rstN     (rstN),
    .enable   (enable),
    .ratioCode(ratioCode),
    .clkOut   (clkOut)
  );

  always #2.5 refClk = ~refClk;

  always @(posedge refClk or negedge refClk) halfCnt++;

  always @(posedge refClk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int high, output int period);
    int r0, f0, r1;
    @(posedge clkOut); r0 = halfCnt;
    @(negedge clkOut); f0 = halfCnt;
    @(posedge clkOut); r1 = halfCnt;
    high = f0 - r0;
    period = r1 - r0;
  endtask

  initial begin
    int hi, per, edgesSeen;
    string tag;

    // R8: output low while reset is held
    repeat (4) @(posedge refClk);
    #1;
    chk("R8 reset low", int'(clkOut), 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      ratioCode = 6'(VEC[i][0]);
      repeat (3) @(posedge clkOut);
      measure(hi, per);
      if (VEC[i][1] == 2) tag = "R3 passthrough period";
      else if (VEC[i][1] % 2 == 1) tag = "R2 half-ratio period";
      else tag = "R1 whole-ratio period";
      chk($sformatf("%s code %0d", tag, VEC[i][0]), per, VEC[i][1]);
      chk($sformatf("R4 high time code %0d", VEC[i][0]), hi, VEC[i][2]);
    end

    // R5: switch from divide-by-48 to divide-by-1.5 mid period
    ratioCode = 6'd50;
    repeat (3) @(posedge clkOut);
    begin
      int r0, f0, r1, f1, r2;
      @(posedge clkOut); r0 = halfCnt;
      repeat (10) @(posedge refClk);
      #1 ratioCode = 6'd1;
      @(negedge clkOut); f0 = halfCnt;
      @(posedge clkOut); r1 = halfCnt;
      @(negedge clkOut); f1 = halfCnt;
      @(posedge clkOut); r2 = halfCnt;
      chk("R5 old high kept", f0 - r0, 48);
      chk("R5 old period kept", r1 - r0, 96);
      chk("R5 new high", f1 - r1, 2);
      chk("R5 new period", r2 - r1, 3);
    end

    // R6: enable low holds output low
    ratioCode = 6'd7;
    repeat (3) @(posedge clkOut);
    @(negedge refClk);
    enable = 1'b0;
    repeat (2) @(posedge refClk);
    edgesSeen = 0;
    fork
      begin
        repeat (40) @(posedge clkOut or negedge clkOut) edgesSeen++;
      end
      begin
        repeat (25) @(posedge refClk);
      end
    join_any
    disable fork;
    #1;
    chk("R6 no edges while disabled", edgesSeen, 0);
    chk("R6 low while disabled", int'(clkOut), 0);

    // R7: first period after enable is whole
    @(negedge refClk);
    enable = 1'b1;
    measure(hi, per);
    chk("R7 first high", hi, 5);
    chk("R7 first period", per, 10);

    // R8: asynchronous reset during a high phase
    ratioCode = 6'd50;
    repeat (2) @(posedge clkOut);
    @(posedge clkOut);
    #1;
    chk("R8 high before reset", int'(clkOut), 1);
    rstN = 1'b0;
    #0.5;
    chk("R8 async reset low", int'(clkOut), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule